// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and a calendar from a 32.768 kHz time base. A free-running prescaler divides that clock down to one pulse per second. Each pulse steps a chain of BCD counters: seconds, minutes, hours, day of month, day of week, month and a two-digit year. The hours can count in either of two forms. In the 24-hour form they run 00 to 23. In the 12-hour form they run 12, 01 to 11 and carry a PM flag.

A host reads and writes the counters through a plain register port: one write strobe with an address, and one read address with combinational read data. Writing a time or date register restarts the prescaler, so a full second passes before the next step. A control register holds four things: the hour form, an interrupt rate (64 Hz, 1 s, 1 min or 1 h), an interrupt enable, and a self-clearing strobe that rounds the time to the nearest minute. A busy output marks the cycle at whose end the counters step, so software can retry a read that overlaps it.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hour 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, control 0x00. The irq output is low.
- R2: Register map: 0 seconds, 1 minutes, 2 hour, 3 day, 4 weekday, 5 month, 6 year, 7 control. All values are packed BCD. In 24-hour form, seconds and minutes wrap 59 to 00 with a carry, hours wrap 23 to 00 with a carry, and a low digit of 9 steps to 0 with the upper digit incremented.
- R3: When control bit 0 is 1, the hour register holds PM in bit 7 and a BCD hour of 01 to 12 in bits 4:0. Hour 11 steps to 12 and inverts PM. Hour 12 steps to 01 with PM unchanged. The date advances only on the step from 11 PM to 12 AM.
- R4: The day advances through 1 to the month length, then returns to 01 and steps the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4 (00 counts as divisible) and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and steps the year, and year 99 wraps to 00.
- R5: The weekday steps once with every day advance and wraps from 6 to 0.
- R6: Writing control with bit 7 set clears the seconds to 00. If the seconds were 0x30 or more, the same write also carries one into the minutes. Bit 7 always reads back as 0.
- R7: A host write to any of addresses 0 to 6 loads the value and restarts the prescaler. The counters then hold for 2^PRE_W - 1 cycles and step at the next edge.
- R8: Control bits 2:1 pick the interrupt rate: 0 every 2^(PRE_W-6) cycles, 1 on each second step, 2 on each minute step, 3 on each hour step. Control bit 3 enables the interrupt. When enabled, irq is a one-cycle pulse in the same cycle the new count becomes visible. When bit 3 is 0, irq stays low.
- R9: busy is high for exactly one cycle per second: the cycle at whose closing edge the seconds step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| busy_o | output | 1 | Counters step at the end of this cycle |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The bench builds the clock with PRE_W = 8. A second then lasts 256 cycles and the fast interrupt fires every 4 cycles. Each case loads a time just short of a boundary and waits a single second for the result. This puts in reach, within a short run, every month-length case (including leap and non-leap Februaries and the century year 00), the year and weekday wraps, all three 12-hour transitions, and the minute and hour interrupt rates.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HOUR = 3'd2,
        RA_DAY  = 3'd3,
        RA_WDAY = 3'd4,
        RA_MON  = 3'd5,
        RA_YEAR = 3'd6,
        RA_CTRL = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        IRQ_FAST = 2'd0,
        IRQ_SEC  = 2'd1,
        IRQ_MIN  = 2'd2,
        IRQ_HOUR = 2'd3
    } irq_rate_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] wday;
        logic [7:0] mon;
        logic [7:0] year;
    } tod_t;

    typedef struct packed {
        logic      irq_en;
        irq_rate_e rate;
        logic      h12;
    } ctrl_t;

    // Packed BCD increment of a two-digit value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick,
    output logic fast_tick
);
    localparam int SUB_W = PRE_W - 6;

    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = restart ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sec_tick  = &cnt_q;
    assign fast_tick = &cnt_q[SUB_W-1:0];
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       adjust,
    input  logic       h12,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output tod_t       tod,
    output logic       sec_evt,
    output logic       min_evt,
    output logic       hour_evt
);
    localparam tod_t TOD_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
                                 wday: 8'h00, mon: 8'h01, year: 8'h00};

    tod_t t_d, t_q;
    logic min_step, hour_step, day_step, mon_step, host_wr;
    logic [7:0] hr_inc;

    assign host_wr = wr_en && (wr_addr != RA_CTRL);
    assign hr_inc  = bcd_inc({3'b000, t_q.hour[4:0]});

    always_comb begin
        t_d       = t_q;
        sec_evt   = 1'b0;
        min_step  = 1'b0;
        hour_step = 1'b0;
        day_step  = 1'b0;
        mon_step  = 1'b0;
        if (host_wr) begin
            case (wr_addr)
                RA_SEC:  t_d.sec  = wr_data;
                RA_MIN:  t_d.min  = wr_data;
                RA_HOUR: t_d.hour = wr_data;
                RA_DAY:  t_d.day  = wr_data;
                RA_WDAY: t_d.wday = wr_data;
                RA_MON:  t_d.mon  = wr_data;
                RA_YEAR: t_d.year = wr_data;
                default: ;
            endcase
        end else begin
            if (adjust) begin
                t_d.sec  = 8'h00;
                min_step = (t_q.sec >= 8'h30);
            end else if (sec_tick) begin
                sec_evt = 1'b1;
                if (t_q.sec == 8'h59) begin
                    t_d.sec  = 8'h00;
                    min_step = 1'b1;
                end else begin
                    t_d.sec = bcd_inc(t_q.sec);
                end
            end
            if (min_step) begin
                if (t_q.min == 8'h59) begin
                    t_d.min   = 8'h00;
                    hour_step = 1'b1;
                end else begin
                    t_d.min = bcd_inc(t_q.min);
                end
            end
            if (hour_step) begin
                if (h12) begin
                    if (t_q.hour[4:0] == 5'h11) begin
                        t_d.hour = {~t_q.hour[7], 7'h12};
                        day_step = t_q.hour[7];
                    end else if (t_q.hour[4:0] == 5'h12) begin
                        t_d.hour = {t_q.hour[7], 7'h01};
                    end else begin
                        t_d.hour = {t_q.hour[7], 2'b00, hr_inc[4:0]};
                    end
                end else if (t_q.hour == 8'h23) begin
                    t_d.hour = 8'h00;
                    day_step = 1'b1;
                end else begin
                    t_d.hour = bcd_inc(t_q.hour);
                end
            end
            if (day_step) begin
                t_d.wday = (t_q.wday >= 8'h06) ? 8'h00 : t_q.wday + 8'h01;
                if (t_q.day == month_len(t_q.mon, t_q.year)) begin
                    t_d.day  = 8'h01;
                    mon_step = 1'b1;
                end else begin
                    t_d.day = bcd_inc(t_q.day);
                end
            end
            if (mon_step) begin
                if (t_q.mon == 8'h12) begin
                    t_d.mon  = 8'h01;
                    t_d.year = (t_q.year == 8'h99) ? 8'h00 : bcd_inc(t_q.year);
                end else begin
                    t_d.mon = bcd_inc(t_q.mon);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= TOD_RST;
        else        t_q <= t_d;
    end

    assign tod      = t_q;
    assign min_evt  = min_step;
    assign hour_evt = hour_step;
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      irq_en,
    input  irq_rate_e rate,
    input  logic      fast_tick,
    input  logic      sec_evt,
    input  logic      min_evt,
    input  logic      hour_evt,
    output logic      irq_o
);
    logic irq_d, irq_q, hit;

    always_comb begin
        case (rate)
            IRQ_FAST: hit = fast_tick;
            IRQ_SEC:  hit = sec_evt;
            IRQ_MIN:  hit = min_evt;
            default:  hit = hour_evt;
        endcase
        irq_d = irq_en & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       busy_o,
    output logic       irq_o
);
    ctrl_t ctrl_d, ctrl_q;
    tod_t  tod_w;
    logic  ctrl_wr, adjust, restart, sec_tick, fast_tick;
    logic  sec_evt, min_evt, hour_evt, irq_en_w;

    assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
    assign adjust   = ctrl_wr && wr_data[7];
    assign restart  = (wr_en && (wr_addr != RA_CTRL)) || adjust;
    assign irq_en_w = ctrl_q.irq_en;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) ctrl_d = ctrl_t'(wr_data[3:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .sec_tick(sec_tick), .fast_tick(fast_tick)
    );

    rtc_chain u_chain (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .adjust(adjust),
        .h12(ctrl_q.h12), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tod(tod_w), .sec_evt(sec_evt), .min_evt(min_evt), .hour_evt(hour_evt)
    );

    rtc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .irq_en(ctrl_q.irq_en), .rate(ctrl_q.rate),
        .fast_tick(fast_tick), .sec_evt(sec_evt), .min_evt(min_evt),
        .hour_evt(hour_evt), .irq_o(irq_o)
    );

    always_comb begin
        case (rd_addr)
            RA_SEC:  rd_data = tod_w.sec;
            RA_MIN:  rd_data = tod_w.min;
            RA_HOUR: rd_data = tod_w.hour;
            RA_DAY:  rd_data = tod_w.day;
            RA_WDAY: rd_data = tod_w.wday;
            RA_MON:  rd_data = tod_w.mon;
            RA_YEAR: rd_data = tod_w.year;
            default: rd_data = {4'b0000, ctrl_q};
        endcase
    end

    assign busy_o = sec_tick;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       busy,
    input logic       irq,
    input logic       irq_en,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] day,
    input logic [7:0] wday
);
    AST_BUSY_STEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wr_en |=> !$stable(sec)); // R9

    AST_IDLE_MIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !wr_en |=> $stable(min)); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq); // R8

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wday <= 8'h06); // R5

    AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (day != 8'h00) && (day <= 8'h31)); // R4
endmodule

bind bcd_rtc rtc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy_o), .irq(irq_o),
    .irq_en(irq_en_w), .sec(tod_w.sec), .min(tod_w.min),
    .day(tod_w.day), .wday(tod_w.wday)
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
    localparam int PRE_W  = 8;
    localparam int SEC_CY = 1 << PRE_W;
    localparam int NVEC   = 13;

    // 0..6 load sec,min,hour,day,wday,mon,year; 7 ctrl; 8..14 expected after one second; 15 req
    localparam logic [7:0] VEC [NVEC][16] = '{
        '{8'h56,8'h34,8'h12,8'h15,8'h02,8'h05,8'h24,8'h00, 8'h57,8'h34,8'h12,8'h15,8'h02,8'h05,8'h24, 8'd2}, // R2
        '{8'h59,8'h59,8'h09,8'h14,8'h02,8'h03,8'h25,8'h00, 8'h00,8'h00,8'h10,8'h14,8'h02,8'h03,8'h25, 8'd2}, // R2
        '{8'h59,8'h59,8'h23,8'h31,8'h06,8'h12,8'h99,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h00,8'h01,8'h00, 8'd5}, // R5 R4
        '{8'h59,8'h59,8'h23,8'h28,8'h01,8'h02,8'h23,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h02,8'h03,8'h23, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h28,8'h03,8'h02,8'h24,8'h00, 8'h00,8'h00,8'h00,8'h29,8'h04,8'h02,8'h24, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h29,8'h05,8'h02,8'h00,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h06,8'h03,8'h00, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h30,8'h00,8'h04,8'h25,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h25, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h30,8'h04,8'h01,8'h25,8'h00, 8'h00,8'h00,8'h00,8'h31,8'h05,8'h01,8'h25, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h30,8'h02,8'h07,8'h19,8'h00, 8'h00,8'h00,8'h00,8'h31,8'h03,8'h07,8'h19, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h31,8'h02,8'h12,8'h19,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h01,8'h20, 8'd4}, // R4
        '{8'h59,8'h59,8'h91,8'h14,8'h02,8'h03,8'h25,8'h01, 8'h00,8'h00,8'h12,8'h15,8'h03,8'h03,8'h25, 8'd3}, // R3
        '{8'h59,8'h59,8'h11,8'h14,8'h02,8'h03,8'h25,8'h01, 8'h00,8'h00,8'h92,8'h14,8'h02,8'h03,8'h25, 8'd3}, // R3
        '{8'h59,8'h59,8'h92,8'h14,8'h02,8'h03,8'h25,8'h01, 8'h00,8'h00,8'h81,8'h14,8'h02,8'h03,8'h25, 8'd3}  // R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy_o, irq_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcd_rtc #(.PRE_W(PRE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_o(busy_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic count_pin(input int cycles, input bit use_irq, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (use_irq ? irq_o : busy_o) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++) begin
            logic [7:0] e;
            e = (a == 3 || a == 5) ? 8'h01 : 8'h00;
            rd(3'(a), v);
            chk("R1", v, e);
        end
        chk("R1 irq", {7'd0, irq_o}, 8'h00);

        // vector table: load, wait one second, compare all registers
        for (int k = 0; k < NVEC; k++) begin
            wr(3'd7, VEC[k][7]);
            for (int a = 0; a < 7; a++) wr(3'(a), VEC[k][a]);
            repeat (SEC_CY + 4) @(negedge clk);
            for (int a = 0; a < 7; a++) begin
                rd(3'(a), v);
                chk($sformatf("R%0d vec %0d reg %0d", VEC[k][15], k, a), v, VEC[k][8+a]);
            end
        end

        // R10-like map check folded into R6: adjust strobe reads back 0
        wr(3'd7, 8'h00);
        wr(3'd0, 8'h45);
        wr(3'd1, 8'h10);
        wr(3'd7, 8'h81);
        rd(3'd0, v); chk("R6 round up sec", v, 8'h00);
        rd(3'd1, v); chk("R6 round up min", v, 8'h11);
        rd(3'd7, v); chk("R6 ctrl readback", v, 8'h01);
        wr(3'd0, 8'h29);
        wr(3'd7, 8'h80);
        rd(3'd0, v); chk("R6 round down sec", v, 8'h00);
        rd(3'd1, v); chk("R6 round down min", v, 8'h11);

        // R7 write restarts the prescaler
        wr(3'd0, 8'h33);
        repeat (SEC_CY - 8) @(negedge clk);
        rd(3'd0, v); chk("R7 hold after write", v, 8'h33);
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R7 step after second", v, 8'h34);

        // R9 busy once per second and sec steps right after it
        count_pin(2 * SEC_CY, 1'b0, n);
        chk("R9 busy count", 8'(n), 8'd2);
        wr(3'd0, 8'h19);
        rd_addr = 3'd0;
        n = 0;
        while (!busy_o && n < 2 * SEC_CY) begin @(negedge clk); n++; end
        #1 chk("R9 sec at busy", rd_data, 8'h19);
        @(negedge clk);
        #1 chk("R9 sec after busy", rd_data, 8'h20);

        // R8 interrupt rates and enable
        wr(3'd7, 8'h08);
        @(negedge clk);
        count_pin(64, 1'b1, n);
        chk("R8 fast rate", 8'(n), 8'd16);
        wr(3'd7, 8'h00);
        @(negedge clk);
        count_pin(64, 1'b1, n);
        chk("R8 disabled", 8'(n), 8'd0);
        wr(3'd7, 8'h0A);
        @(negedge clk);
        count_pin(2 * SEC_CY, 1'b1, n);
        chk("R8 second rate", 8'(n), 8'd2);
        wr(3'd7, 8'h0C);
        wr(3'd1, 8'h05);
        wr(3'd0, 8'h59);
        count_pin(SEC_CY + 40, 1'b1, n);
        chk("R8 minute rate", 8'(n), 8'd1);
        wr(3'd0, 8'h10);
        count_pin(SEC_CY + 40, 1'b1, n);
        chk("R8 minute quiet", 8'(n), 8'd0);
        wr(3'd7, 8'h0E);
        wr(3'd1, 8'h59);
        wr(3'd0, 8'h59);
        count_pin(SEC_CY + 40, 1'b1, n);
        chk("R8 hour rate", 8'(n), 8'd1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule